// File: doc/BRIEF.md
# CKE Power-Mode Sequencer

This block sits on the controller side of a DDR2-style memory interface. It owns the clock-enable line and the final command slot. While the memory is awake, commands from the scheduler go out one edge later. When a client asks for power-down or self refresh, the block picks the right low-power state from the bank-open status. It then drops clock enable on an edge that carries only a NOP or a REFRESH. Later it raises clock enable again, on a NOP edge, when a wake request arrives.

The block also enforces the rules around those transitions:
- Clock enable holds each new level for a minimum number of edges.
- Entry waits while a read, write, mode-register set or precharge is in flight, or while calibration is running.
- A power-down stay ends by itself before the refresh deadline.
- After self refresh ends, a short window blocks every command and a longer window blocks reads. A read-permitted flag tells the scheduler when reads are allowed again.

Requests that fit no legal transition raise an error pulse and change nothing.

Top module: `cke_pwr_seq`

## Requirements
- R1: After reset, `cke` is 1, `cmdOut` is NOP, `pwrState` is 0, `readOk` is 1, `ready` is 1 and `errPulse` is 0. Command codes: 0 NOP, 1 DESELECT, 2 REFRESH, 3 READ, 4 WRITE, 5 ACTIVATE, 6 PRECHARGE, 7 MODE-SET. State codes: 0 awake, 1 active power-down, 2 precharge power-down, 3 self refresh.
- R2: While awake and outside any exit window, the code on `cmdIn` at an edge appears on `cmdOut` after that edge, unchanged.
- R3: An accepted `reqPd` drives `cke` low and `cmdOut` to NOP at the next edge. The command on `cmdIn` at that edge is dropped. The new state is 1 if `bankOpen` is high, otherwise 2.
- R4: An accepted `reqSr` with `bankOpen` low drives `cke` low and `cmdOut` to REFRESH at the next edge, and the state becomes 3. Self refresh is never entered while a bank is open.
- R5: While in a low-power state, `cmdOut` is DESELECT and `cke` stays low. An accepted `reqWake` raises `cke` and sends NOP at the next edge, and the state becomes 0.
- R6: Once `cke` changes at an edge, it keeps that level on the following CKE_HOLD-1 edges. Requests that would change it earlier wait and are not flagged as errors.
- R7: On the self-refresh exit edge, the edge itself and the next EXIT_NONREAD edges send NOP, and `ready` is low until the last of them. A READ is replaced by NOP up to and including the EXIT_READ-th edge after exit. `readOk` goes high right after that edge.
- R8: An entry request waits without error while `opBusy` or `calActive` is high, or inside the post-exit NOP window. `cke` stays high while `calActive` is high.
- R9: After PD_LIMIT edges in either power-down state, the block leaves power-down on its own (`cke` high, NOP). Self refresh has no such limit.
- R10: Each of the following is illegal: `reqSr` with `bankOpen` high, `reqWake` while awake, `reqPd` or `reqSr` while low, or `reqPd` and `reqSr` together. An illegal request sets `errPulse` for one cycle after the edge that sampled it, and `cke` and the state are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqPd | input | 1 | Request power-down (level) |
| reqSr | input | 1 | Request self refresh (level) |
| reqWake | input | 1 | Request exit from a low-power state (level) |
| bankOpen | input | 1 | At least one bank is open |
| opBusy | input | 1 | Read, write, mode-set or precharge in flight |
| calActive | input | 1 | Output-driver calibration running |
| cmdIn | input | 3 | Command from the scheduler |
| cke | output | 1 | Clock enable to the memory |
| cmdOut | output | 3 | Command to the memory |
| ready | output | 1 | Awake and outside the post-exit NOP window |
| readOk | output | 1 | Reads may be issued |
| errPulse | output | 1 | Illegal request seen at the last edge |
| pwrState | output | 2 | Current power state code |

## Verification
Every output is registered, so each result of a stimulus applied after edge n is due after edge n+1. The exceptions are the delays set by the rules. A request blocked by the hold rule lands CKE_HOLD edges after the previous change. The forced power-down exit lands PD_LIMIT edges after entry. The post-self-refresh windows end EXIT_NONREAD and EXIT_READ edges after the exit edge. The driver pushes each expected output word into a queue with its due cycle, computed from those counts. The monitor compares the words at the falling edge of exactly that cycle, and one check sits on each side of every window boundary.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_DESEL = 3'd1,
    CMD_REF   = 3'd2,
    CMD_READ  = 3'd3,
    CMD_WRITE = 3'd4,
    CMD_ACT   = 3'd5,
    CMD_PRE   = 3'd6,
    CMD_MRS   = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    PS_AWAKE   = 2'd0,
    PS_ACT_PD  = 2'd1,
    PS_PRE_PD  = 2'd2,
    PS_SELF_RF = 2'd3
  } pwr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic goLow;     // drop clock enable this edge
    logic goHigh;    // raise clock enable this edge
    logic issueRef;  // entry edge carries REFRESH (self refresh)
    logic srExit;    // wake from self refresh: start exit windows
    logic flagErr;   // illegal request sampled this edge
  } strobe_t;

endpackage

// File: rtl/cke_pwr_ctrl.sv
module cke_pwr_ctrl
  import cke_pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqPd,
  input  logic    reqSr,
  input  logic    reqWake,
  input  logic    bankOpen,
  input  logic    opBusy,
  input  logic    calActive,
  input  logic    holdOk,
  input  logic    nonReadWin,
  input  logic    deadlineHit,
  output pwr_e    state,
  output strobe_t strb
);

  pwr_e stateNext;
  logic illegal;
  logic entryReq;
  logic entryClear;
  logic wakeNow;

  assign entryReq   = reqPd | reqSr;
  assign entryClear = holdOk & ~opBusy & ~calActive & ~nonReadWin;

  always_comb begin
    stateNext = state;
    strb      = '0;
    illegal   = 1'b0;
    wakeNow   = 1'b0;
    unique case (state)
      PS_AWAKE: begin
        if ((reqPd && reqSr) || reqWake || (reqSr && bankOpen)) begin
          illegal = 1'b1;
        end else if (entryReq && entryClear) begin
          strb.goLow = 1'b1;
          if (reqSr) begin
            strb.issueRef = 1'b1;
            stateNext     = PS_SELF_RF;
          end else begin
            stateNext = bankOpen ? PS_ACT_PD : PS_PRE_PD;
          end
        end
      end
      PS_ACT_PD, PS_PRE_PD, PS_SELF_RF: begin
        wakeNow = reqWake || (deadlineHit && (state != PS_SELF_RF));
        if (entryReq) begin
          illegal = 1'b1;
        end else if (wakeNow && holdOk) begin
          strb.goHigh = 1'b1;
          strb.srExit = (state == PS_SELF_RF);
          stateNext   = PS_AWAKE;
        end
      end
      default: stateNext = PS_AWAKE;
    endcase
    strb.flagErr = illegal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_AWAKE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/cke_pwr_dp.sv
module cke_pwr_dp
  import cke_pwr_pkg::*;
#(
  parameter int unsigned CKE_HOLD      = 3,
  parameter int unsigned EXIT_NONREAD  = 10,
  parameter int unsigned EXIT_READ     = 200,
  parameter int unsigned PD_LIMIT      = 64,
  parameter bit          LP_IDLE_DESEL = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  pwr_e       state,
  input  logic [2:0] cmdIn,
  output logic       holdOk,
  output logic       nonReadWin,
  output logic       deadlineHit,
  output logic       cke,
  output logic [2:0] cmdOut,
  output logic       ready,
  output logic       readOk,
  output logic       errPulse
);

  localparam int unsigned HOLD_W = $clog2(CKE_HOLD + 1);
  localparam int unsigned NR_W   = $clog2(EXIT_NONREAD + 1);
  localparam int unsigned RD_W   = $clog2(EXIT_READ + 1);
  localparam int unsigned PD_W   = $clog2(PD_LIMIT + 1);

  logic [HOLD_W-1:0] holdCnt;
  logic [NR_W-1:0]   nrCnt;
  logic [RD_W-1:0]   rdCnt;
  logic [PD_W-1:0]   pdCnt;
  cmd_e              cmdReg;
  cmd_e              cmdNext;
  cmd_e              lpIdleCmd;
  cmd_e              cmdInE;
  logic              inPd;
  logic              readHeld;

  generate
    if (LP_IDLE_DESEL) begin : g_idleDesel
      assign lpIdleCmd = CMD_DESEL;
    end else begin : g_idleNop
      assign lpIdleCmd = CMD_NOP;
    end
  endgenerate

  assign cmdInE      = cmd_e'(cmdIn);
  assign holdOk      = (holdCnt >= HOLD_W'(CKE_HOLD - 1));
  assign nonReadWin  = (nrCnt != '0);
  assign readHeld    = (rdCnt != '0);
  assign inPd        = (state == PS_ACT_PD) || (state == PS_PRE_PD);
  assign deadlineHit = (pdCnt == PD_W'(PD_LIMIT - 1));

  // command selection for the coming edge
  always_comb begin
    if (strb.goLow)                              cmdNext = strb.issueRef ? CMD_REF : CMD_NOP;
    else if (strb.goHigh)                        cmdNext = CMD_NOP;
    else if (state != PS_AWAKE)                  cmdNext = lpIdleCmd;
    else if (nonReadWin)                         cmdNext = CMD_NOP;
    else if (cmdInE == CMD_READ && readHeld)     cmdNext = CMD_NOP;
    else                                         cmdNext = cmdInE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke      <= 1'b1;
      holdCnt  <= HOLD_W'(CKE_HOLD - 1);
      cmdReg   <= CMD_NOP;
      errPulse <= 1'b0;
    end else begin
      errPulse <= strb.flagErr;
      cmdReg   <= cmdNext;
      if (strb.goLow) begin
        cke     <= 1'b0;
        holdCnt <= '0;
      end else if (strb.goHigh) begin
        cke     <= 1'b1;
        holdCnt <= '0;
      end else if (!holdOk) begin
        holdCnt <= holdCnt + HOLD_W'(1);
      end
    end
  end

  // post self-refresh exit windows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nrCnt <= '0;
      rdCnt <= '0;
    end else if (strb.srExit) begin
      nrCnt <= NR_W'(EXIT_NONREAD);
      rdCnt <= RD_W'(EXIT_READ);
    end else begin
      if (nonReadWin) nrCnt <= nrCnt - NR_W'(1);
      if (readHeld)   rdCnt <= rdCnt - RD_W'(1);
    end
  end

  // refresh deadline while in power-down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     pdCnt <= '0;
    else if (strb.goLow)           pdCnt <= '0;
    else if (inPd && !deadlineHit) pdCnt <= pdCnt + PD_W'(1);
  end

  assign cmdOut = cmdReg;
  assign ready  = (state == PS_AWAKE) && !nonReadWin;
  assign readOk = (state == PS_AWAKE) && !readHeld;

endmodule

// File: rtl/cke_pwr_seq.sv
module cke_pwr_seq
  import cke_pwr_pkg::*;
#(
  parameter int unsigned CKE_HOLD      = 3,
  parameter int unsigned EXIT_NONREAD  = 10,
  parameter int unsigned EXIT_READ     = 200,
  parameter int unsigned PD_LIMIT      = 64,
  parameter bit          LP_IDLE_DESEL = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqPd,
  input  logic       reqSr,
  input  logic       reqWake,
  input  logic       bankOpen,
  input  logic       opBusy,
  input  logic       calActive,
  input  logic [2:0] cmdIn,
  output logic       cke,
  output logic [2:0] cmdOut,
  output logic       ready,
  output logic       readOk,
  output logic       errPulse,
  output logic [1:0] pwrState
);

  strobe_t strb;
  pwr_e    state;
  logic    holdOk;
  logic    nonReadWin;
  logic    deadlineHit;

  cke_pwr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqPd      (reqPd),
    .reqSr      (reqSr),
    .reqWake    (reqWake),
    .bankOpen   (bankOpen),
    .opBusy     (opBusy),
    .calActive  (calActive),
    .holdOk     (holdOk),
    .nonReadWin (nonReadWin),
    .deadlineHit(deadlineHit),
    .state      (state),
    .strb       (strb)
  );

  cke_pwr_dp #(
    .CKE_HOLD     (CKE_HOLD),
    .EXIT_NONREAD (EXIT_NONREAD),
    .EXIT_READ    (EXIT_READ),
    .PD_LIMIT     (PD_LIMIT),
    .LP_IDLE_DESEL(LP_IDLE_DESEL)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .state      (state),
    .cmdIn      (cmdIn),
    .holdOk     (holdOk),
    .nonReadWin (nonReadWin),
    .deadlineHit(deadlineHit),
    .cke        (cke),
    .cmdOut     (cmdOut),
    .ready      (ready),
    .readOk     (readOk),
    .errPulse   (errPulse)
  );

  assign pwrState = state;

endmodule

// File: rtl/cke_pwr_seq_chk.sv
module cke_pwr_seq_chk
  import cke_pwr_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cke,
  input logic [2:0] cmdOut,
  input logic       readOk,
  input logic       errPulse,
  input logic [1:0] pwrState,
  input logic       calActive,
  input logic       bankOpen
);

  assert_hold_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cke) || $fell(cke)) |=> $stable(cke));

  assert_hold_second_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cke) || $fell(cke)) |=> ##1 $stable(cke));

  assert_entry_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> (cmdOut == CMD_NOP || cmdOut == CMD_REF));

  assert_exit_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (cmdOut == CMD_NOP));

  assert_sr_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cke) && cmdOut == CMD_REF) |-> (!$past(bankOpen) && pwrState == PS_SELF_RF));

  assert_cal_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (calActive && cke) |=> cke);

  assert_read_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    !readOk |=> (cmdOut != CMD_READ));

  assert_err_nochange_R10: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> ($stable(pwrState) && $stable(cke)));

endmodule

bind cke_pwr_seq cke_pwr_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cke      (cke),
  .cmdOut   (cmdOut),
  .readOk   (readOk),
  .errPulse (errPulse),
  .pwrState (pwrState),
  .calActive(calActive),
  .bankOpen (bankOpen)
);

// File: tb/cke_pwr_seq_bench.sv
`timescale 1ns/1ps
module cke_pwr_seq_bench;

  localparam logic [2:0] NOP = 3'd0, DES = 3'd1, REF = 3'd2, RD = 3'd3, WR = 3'd4, ACT = 3'd5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqPd = 0, reqSr = 0, reqWake = 0, bankOpen = 0, opBusy = 0, calActive = 0;
  logic [2:0] cmdIn = NOP;
  logic cke, ready, readOk, errPulse;
  logic [2:0] cmdOut;
  logic [1:0] pwrState;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    int         due;
    string      req;
    logic [8:0] word;  // {cke, cmd[2:0], state[1:0], readOk, ready, err}
  } exp_t;
  exp_t expQ[$];

  cke_pwr_seq u_cke_pwr_seq (
    .clk(clk), .rstN(rstN), .reqPd(reqPd), .reqSr(reqSr), .reqWake(reqWake),
    .bankOpen(bankOpen), .opBusy(opBusy), .calActive(calActive), .cmdIn(cmdIn),
    .cke(cke), .cmdOut(cmdOut), .ready(ready), .readOk(readOk),
    .errPulse(errPulse), .pwrState(pwrState)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic expectAt(int off, string r, logic c, logic [2:0] m, logic [1:0] s,
                          logic rd, logic rdy, logic e);
    exp_t it;
    it.due  = cyc + off;
    it.req  = r;
    it.word = {c, m, s, rd, rdy, e};
    expQ.push_back(it);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    logic [8:0] act;
    act = {cke, cmdOut, pwrState, readOk, ready, errPulse};
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].due == cyc) begin
        checks++;
        if (act !== expQ[i].word) begin
          failures++;
          $display("FAIL %s cycle %0d actual=%b expected=%b", expQ[i].req, cyc, act, expQ[i].word);
        end
        expQ.delete(i);
      end
    end
    if (cyc > 5000 && !done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog cycle %0d actual=running expected=finished", cyc);
      summary();
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    expectAt(0, "R1", 1, NOP, 0, 1, 1, 0);
    tick(1);

    // R2 pass-through
    cmdIn = ACT; expectAt(1, "R2", 1, ACT, 0, 1, 1, 0); tick(1);
    cmdIn = WR;  expectAt(1, "R2", 1, WR,  0, 1, 1, 0); tick(1);
    cmdIn = RD;  expectAt(1, "R2", 1, RD,  0, 1, 1, 0); tick(1);
    cmdIn = NOP; tick(3);

    // R3 precharge power-down entry, dropped command
    bankOpen = 0; reqPd = 1; cmdIn = WR;
    expectAt(1, "R3", 0, NOP, 2, 0, 0, 0);
    tick(1);
    reqPd = 0; cmdIn = NOP; reqWake = 1;
    // R6 wake waits for hold, R5 exit
    expectAt(1, "R5", 0, DES, 2, 0, 0, 0);
    expectAt(2, "R6", 0, DES, 2, 0, 0, 0);
    expectAt(3, "R5", 1, NOP, 0, 1, 1, 0);
    tick(3);
    reqWake = 0;
    // R6 high level held before active power-down entry
    reqPd = 1; bankOpen = 1;
    expectAt(1, "R6", 1, NOP, 0, 1, 1, 0);
    expectAt(2, "R6", 1, NOP, 0, 1, 1, 0);
    expectAt(3, "R3", 0, NOP, 1, 0, 0, 0);
    tick(3);
    reqPd = 0;
    // R9 refresh deadline forces exit
    expectAt(63, "R9", 0, DES, 1, 0, 0, 0);
    expectAt(64, "R9", 1, NOP, 0, 1, 1, 0);
    tick(64);
    tick(3);

    // R10 illegal requests (R4 self refresh with open bank)
    bankOpen = 1; reqSr = 1;
    expectAt(1, "R10", 1, NOP, 0, 1, 1, 1);
    tick(1);
    reqSr = 0;
    expectAt(1, "R10", 1, NOP, 0, 1, 1, 0);
    tick(1);
    reqWake = 1;
    expectAt(1, "R10", 1, NOP, 0, 1, 1, 1);
    tick(1);
    reqWake = 0; bankOpen = 0; reqPd = 1; reqSr = 1;
    expectAt(1, "R10", 1, NOP, 0, 1, 1, 1);
    tick(1);
    reqPd = 0; reqSr = 0;
    expectAt(1, "R10", 1, NOP, 0, 1, 1, 0);
    tick(1);

    // R8 defer while operation in progress
    opBusy = 1; reqPd = 1;
    expectAt(1, "R8", 1, NOP, 0, 1, 1, 0);
    expectAt(2, "R8", 1, NOP, 0, 1, 1, 0);
    tick(2);
    opBusy = 0;
    expectAt(1, "R8", 0, NOP, 2, 0, 0, 0);
    tick(1);
    reqPd = 0; reqWake = 1;
    expectAt(3, "R5", 1, NOP, 0, 1, 1, 0);
    tick(3);
    reqWake = 0;
    tick(3);

    // R8 defer while calibrating, then R4 self refresh entry
    calActive = 1; reqSr = 1;
    expectAt(1, "R8", 1, NOP, 0, 1, 1, 0);
    expectAt(2, "R8", 1, NOP, 0, 1, 1, 0);
    tick(2);
    calActive = 0;
    expectAt(1, "R4", 0, REF, 3, 0, 0, 0);
    tick(1);
    reqSr = 0;
    // R9 no deadline in self refresh
    expectAt(80, "R9", 0, DES, 3, 0, 0, 0);
    tick(10);
    reqPd = 1;
    expectAt(1, "R10", 0, DES, 3, 0, 0, 1);
    tick(1);
    reqPd = 0;
    tick(70);

    // R7 self refresh exit windows
    reqWake = 1;
    expectAt(1, "R5", 1, NOP, 0, 0, 0, 0);
    tick(1);
    reqWake = 0; cmdIn = WR;
    expectAt(9,  "R7", 1, NOP, 0, 0, 0, 0);
    expectAt(10, "R7", 1, NOP, 0, 0, 1, 0);
    expectAt(11, "R7", 1, WR,  0, 0, 1, 0);
    tick(11);
    cmdIn = RD;
    expectAt(188, "R7", 1, NOP, 0, 0, 1, 0);
    expectAt(189, "R7", 1, NOP, 0, 1, 1, 0);
    expectAt(190, "R7", 1, RD,  0, 1, 1, 0);
    tick(191);
    cmdIn = NOP;
    tick(3);

    if (expQ.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard actual=%0d pending expected=0", expQ.size());
    end
    done = 1;
    summary();
  end

endmodule